// File: doc/BRIEF.md
# Audio Port Control-Status Synchroniser

This block is the single control and status word of a serial audio port. The word lives in the bus clock domain. The port's serialiser runs on a separate bit clock. The block holds the port's control fields: enable, per-direction run bits, DMA enable, FIFO thresholds, sign-extend enable and standby. It passes the run-time levels into the bit-clock domain through synchronisers. It also turns software requests for a FIFO flush into single bit-clock pulses, and reports back when each pulse has been delivered.

A round-trip probe bit lets software confirm that the bit clock is alive and that earlier writes have crossed. After a write, the probe reads its new value only when that value has gone to the bit-clock domain and come back. Status flags and error events that the bit-clock side raises are brought back into the word. Error events are held as sticky flags until software clears them. Leaving standby is reported to the bit-clock side only after a programmable number of bit-clock cycles.

Top module: `acs_ctrl_sync`

## Requirements
- R1: After reset, `rd_data` reads 0 (status inputs low) and `b_en`, `b_tx_on`, `b_rx_on`, `b_ready`, `b_tx_clr` and `b_rx_clr` are low.
- R2: A write loads the read-write fields: enable (bit 0), receive run (bit 1), transmit run (bit 2), transmit threshold (bits 6:5), receive threshold (bits 8:7), DMA enable (bit 9) and sign-extend enable (bit 23). On the read after the write, these bits read back as written.
- R3: `b_en`, `b_rx_on` and `b_tx_on` follow bits 0, 1 and 2 in the bit-clock domain within a few bit-clock cycles. Clearing one run bit leaves the other direction's level unchanged.
- R4: Writing 1 to bit 3 (transmit flush) or bit 4 (receive flush) gives exactly one pulse, one bit-clock cycle wide, on `b_tx_clr` or `b_rx_clr` respectively. The bit reads 1 from the write until the pulse has been acknowledged back, then reads 0. Writing 0 gives no pulse. A flush request written while the same flush is still pending is ignored.
- R5: A write sets the probe request to bit 24 of the written data. Bit 24 keeps its previous value on the read right after the write. It shows the written value only once the request has gone to the bit-clock domain and come back.
- R6: Bit 25 (standby release) reads back as written. `b_ready` rises only after bit 25 has been seen in the bit-clock domain for `STBY_CYCLES` (default 4) bit-clock cycles. It falls within a few bit-clock cycles after bit 25 is cleared.
- R7: `b_flags` is mapped into the word as follows: [0] to bit 13, [1] to bit 14, and [2]..[7] to bits 17..22. These bits are read-only, and writes to them have no effect.
- R8: A one-cycle pulse on `b_tx_underrun` or `b_rx_overrun` sets sticky bit 15 or bit 16. The flag stays set through writes of 0 to that bit, and a write of 1 to that bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control and status word |
| bclk | input | 1 | Serial bit clock |
| brst_n | input | 1 | Bit-clock-domain reset, active low |
| b_en | output | 1 | Block enable, bit-clock domain |
| b_tx_on | output | 1 | Transmit run, bit-clock domain |
| b_rx_on | output | 1 | Receive run, bit-clock domain |
| b_ready | output | 1 | Standby released and settled |
| b_tx_clr | output | 1 | Transmit FIFO flush pulse |
| b_rx_clr | output | 1 | Receive FIFO flush pulse |
| b_flags | input | 8 | Bit-clock status flags |
| b_tx_underrun | input | 1 | Transmit underrun event pulse |
| b_rx_overrun | input | 1 | Receive overrun event pulse |

## Verification
The bench writes a flush request twice in back-to-back cycles. A design without the pending guard would give two pulses, and a design with a level handshake would give a pulse several cycles wide. The bench reads the probe bit on the cycle right after a write. A design that loops the request straight back would show the new value at once. It samples `b_ready` four bit-clock edges after standby is released, which catches a timer that is too short or missing. It writes 0 and then 1 to a set error flag, and writes random data over the read-only status positions. A design that clears on any write, or that stores written status bits, would show a wrong word.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int WORD_W    = 32;
  localparam int FLAG_W    = 8;
  localparam int B_TXCLR   = 3;
  localparam int B_RXCLR   = 4;
  localparam int B_TXERR   = 15;
  localparam int B_RXERR   = 16;
  localparam int B_PROBE   = 24;
  localparam int B_STBY    = 25;
  localparam logic [WORD_W-1:0] RW_MASK   = 32'h0080_03E7;
  localparam logic [WORD_W-1:0] FLAG_MASK = 32'h007E_6000;

  // place the bit-clock status flags at their word positions
  function automatic logic [WORD_W-1:0] place_flags(input logic [FLAG_W-1:0] f);
    logic [WORD_W-1:0] w;
    w = '0;
    w[13] = f[0];
    w[14] = f[1];
    w[22:17] = f[7:2];
    return w;
  endfunction

  // next value of a sticky flag: event sets, write-one clears, set wins
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic wr1);
    return set | (cur & ~wr1);
  endfunction
endpackage

// File: rtl/acs_sync2.sv
module acs_sync2 #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/acs_pulse_xfer.sv
module acs_pulse_xfer #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  input  logic bclk,
  input  logic brst_n,
  output logic b_pulse
);
  logic req_q, ack_s, r_s, r_d;
  logic accept;

  assign busy   = req_q ^ ack_s;
  assign accept = start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else if (accept) req_q <= ~req_q;
  end

  acs_sync2 #(.W(1), .STAGES(STAGES)) u_req (
    .clk(bclk), .rst_n(brst_n), .d(req_q), .q(r_s));

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) r_d <= 1'b0;
    else r_d <= r_s;
  end

  assign b_pulse = r_s ^ r_d;

  acs_sync2 #(.W(1), .STAGES(STAGES)) u_ack (
    .clk(clk), .rst_n(rst_n), .d(r_d), .q(ack_s));

  assert_flush_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_flush_single_R4: assert property (@(posedge bclk) disable iff (!brst_n)
    b_pulse |=> !b_pulse);
endmodule

// File: rtl/acs_stby_timer.sv
module acs_stby_timer #(
  parameter int STBY_CYCLES = 4
) (
  input  logic bclk,
  input  logic brst_n,
  input  logic lvl,
  output logic ready
);
  localparam int CW = $clog2(STBY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STBY_CYCLES);
  logic [CW-1:0] cnt;

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) cnt <= '0;
    else if (!lvl) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == LAST);

  assert_stby_drop_R6: assert property (@(posedge bclk) disable iff (!brst_n)
    !lvl |=> !ready);
  assert_stby_rise_R6: assert property (@(posedge bclk) disable iff (!brst_n)
    $rose(ready) |-> $past(lvl));
endmodule

// File: rtl/acs_ctrl_sync.sv
module acs_ctrl_sync
  import acs_pkg::*;
#(
  parameter int STAGES      = 2,
  parameter int STBY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              bclk,
  input  logic              brst_n,
  output logic              b_en,
  output logic              b_tx_on,
  output logic              b_rx_on,
  output logic              b_ready,
  output logic              b_tx_clr,
  output logic              b_rx_clr,
  input  logic [FLAG_W-1:0] b_flags,
  input  logic              b_tx_underrun,
  input  logic              b_rx_overrun
);
  logic [WORD_W-1:0] rw_q;
  logic probe_q, stby_q, tx_err_q, rx_err_q;
  logic [1:0] clr_busy, clr_pulse;
  logic [4:0] b_lvl;
  logic b_probe, b_stby;
  logic [1:0] b_err_tgl, err_tgl_s, err_tgl_d, err_set;
  logic [FLAG_W-1:0] flags_s;
  logic probe_rb;
  logic unused_wr;

  assign unused_wr = ^{wr_data[31:26], wr_data[12:10]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q    <= '0;
      probe_q <= 1'b0;
      stby_q  <= 1'b0;
    end else if (wr_en) begin
      rw_q    <= wr_data & RW_MASK;
      probe_q <= wr_data[B_PROBE];
      stby_q  <= wr_data[B_STBY];
    end
  end

  // flush strobes, one handshake per direction
  for (genvar i = 0; i < 2; i++) begin : g_flush
    acs_pulse_xfer #(.STAGES(STAGES)) u_xfer (
      .clk(clk), .rst_n(rst_n),
      .start(wr_en & wr_data[B_TXCLR+i]),
      .busy(clr_busy[i]),
      .bclk(bclk), .brst_n(brst_n),
      .b_pulse(clr_pulse[i]));
  end
  assign b_tx_clr = clr_pulse[0];
  assign b_rx_clr = clr_pulse[1];

  // control levels into the bit-clock domain
  acs_sync2 #(.W(5), .STAGES(STAGES)) u_fwd (
    .clk(bclk), .rst_n(brst_n),
    .d({probe_q, stby_q, rw_q[2], rw_q[1], rw_q[0]}),
    .q(b_lvl));
  assign b_en    = b_lvl[0];
  assign b_rx_on = b_lvl[1];
  assign b_tx_on = b_lvl[2];
  assign b_stby  = b_lvl[3];
  assign b_probe = b_lvl[4];

  acs_stby_timer #(.STBY_CYCLES(STBY_CYCLES)) u_stby (
    .bclk(bclk), .brst_n(brst_n), .lvl(b_stby), .ready(b_ready));

  // error events become toggles before crossing back
  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) b_err_tgl <= '0;
    else b_err_tgl <= b_err_tgl ^ {b_rx_overrun, b_tx_underrun};
  end

  acs_sync2 #(.W(FLAG_W + 3), .STAGES(STAGES)) u_back (
    .clk(clk), .rst_n(rst_n),
    .d({b_probe, b_err_tgl, b_flags}),
    .q({probe_rb, err_tgl_s, flags_s}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_tgl_d <= '0;
      tx_err_q  <= 1'b0;
      rx_err_q  <= 1'b0;
    end else begin
      err_tgl_d <= err_tgl_s;
      tx_err_q  <= sticky_next(tx_err_q, err_set[0], wr_en & wr_data[B_TXERR]);
      rx_err_q  <= sticky_next(rx_err_q, err_set[1], wr_en & wr_data[B_RXERR]);
    end
  end
  assign err_set = err_tgl_s ^ err_tgl_d;

  always_comb begin
    rd_data = rw_q | place_flags(flags_s);
    rd_data[B_TXCLR] = clr_busy[0];
    rd_data[B_RXCLR] = clr_busy[1];
    rd_data[B_TXERR] = tx_err_q;
    rd_data[B_RXERR] = rx_err_q;
    rd_data[B_PROBE] = probe_rb;
    rd_data[B_STBY]  = stby_q;
  end

  assert_tx_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err_q && !(wr_en && wr_data[B_TXERR]) |=> tx_err_q);
  assert_rx_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_q && !(wr_en && wr_data[B_RXERR]) |=> rx_err_q);
  assert_rw_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[2:0] == $past(wr_data[2:0]));
endmodule

// File: tb/sim_acs_ctrl_sync.sv
module sim_acs_ctrl_sync;
  localparam int CLK_PERIOD  = 10;
  localparam int BCLK_PERIOD = 26;
  localparam logic [31:0] RWM = 32'h0080_03E7;
  localparam logic [31:0] FLM = 32'h007E_6000;

  logic clk = 0, bclk = 0, rst_n = 0, brst_n = 0;
  logic wr_en = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic b_en, b_tx_on, b_rx_on, b_ready, b_tx_clr, b_rx_clr;
  logic [7:0] b_flags = 0;
  logic b_tx_underrun = 0, b_rx_overrun = 0;

  int checks = 0, errors = 0, cyc = 0;
  int n_txclr = 0, n_rxclr = 0;
  logic [31:0] ctrl_m = 0;
  logic sync_m = 0, stby_m = 0, te_m = 0, re_m = 0;
  logic [7:0] fl_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(BCLK_PERIOD/2) bclk = ~bclk;

  acs_ctrl_sync u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .bclk(bclk), .brst_n(brst_n), .b_en(b_en),
    .b_tx_on(b_tx_on), .b_rx_on(b_rx_on), .b_ready(b_ready),
    .b_tx_clr(b_tx_clr), .b_rx_clr(b_rx_clr), .b_flags(b_flags),
    .b_tx_underrun(b_tx_underrun), .b_rx_overrun(b_rx_overrun));

  always @(negedge bclk) begin
    if (b_tx_clr) n_txclr++;
    if (b_rx_clr) n_rxclr++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] map_flags(input logic [7:0] f);
    logic [31:0] w = 0;
    w[13] = f[0]; w[14] = f[1];
    for (int i = 2; i < 8; i++) w[15 + i] = f[i];
    return w;
  endfunction

  function automatic logic [31:0] base_word();
    return ctrl_m | (32'(sync_m) << 24) | (32'(stby_m) << 25);
  endfunction

  function automatic logic [31:0] exp_word();
    return base_word() | map_flags(fl_m) | (32'(te_m) << 15) | (32'(re_m) << 16);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    int t0, r0;
    void'($urandom(32'd4242));
    wait_clk(3);
    rst_n = 1; brst_n = 1;
    wait_clk(2);
    // R1 reset state
    chk("R1 word", rd_data, 0);
    chk("R1 bclk outs", {26'd0, b_en, b_tx_on, b_rx_on, b_ready, b_tx_clr, b_rx_clr}, 0);

    // R2 / R3 random control writes
    for (int k = 0; k < 8; k++) begin
      ctrl_m = $urandom & RWM;
      wr(base_word());
      chk("R2 readback", rd_data, exp_word());
      repeat (4) @(posedge bclk);
      wait_clk(1);
      chk("R3 levels", {29'd0, b_en, b_rx_on, b_tx_on}, {29'd0, ctrl_m[0], ctrl_m[1], ctrl_m[2]});
    end

    // R3 stop one direction
    ctrl_m = 32'h7; wr(base_word());
    repeat (4) @(posedge bclk);
    ctrl_m = 32'h3; wr(base_word());
    repeat (4) @(posedge bclk); wait_clk(1);
    chk("R3 tx stopped rx running", {30'd0, b_tx_on, b_rx_on}, 32'h1);

    // R4 flush strobes
    wr(base_word() | 32'h8);
    chk("R4 tx pending", rd_data, exp_word() | 32'h8);
    wait_clk(40);
    chk("R4 tx settled", rd_data, exp_word());
    chk("R4 tx pulse count", 32'(n_txclr), 1);
    chk("R4 rx no pulse", 32'(n_rxclr), 0);
    wr(base_word() | 32'h10);
    chk("R4 rx pending", rd_data, exp_word() | 32'h10);
    wait_clk(40);
    chk("R4 rx pulse count", 32'(n_rxclr), 1);
    chk("R4 tx unchanged", 32'(n_txclr), 1);
    wr(base_word());
    wait_clk(40);
    chk("R4 zero write no pulse", 32'(n_txclr + n_rxclr), 2);
    wr(base_word() | 32'h8);
    wr(base_word() | 32'h8);
    wait_clk(40);
    chk("R4 repeat while pending", 32'(n_txclr), 2);

    // R5 round-trip probe
    for (int k = 0; k < 3; k++) begin
      wr(base_word() ^ (32'h1 << 24));
      chk("R5 old value right after write", 32'(rd_data[24]), 32'(sync_m));
      sync_m = ~sync_m;
      t0 = cyc;
      while (rd_data[24] !== sync_m && cyc - t0 < 100) wait_clk(1);
      chk("R5 new value after round trip", rd_data, exp_word());
      chk("R5 min delay", 32'(cyc - t0 >= 2), 1);
    end

    // R6 standby release
    stby_m = 1; wr(base_word());
    chk("R6 readback", rd_data, exp_word());
    repeat (4) @(posedge bclk); #1;
    chk("R6 not ready early", 32'(b_ready), 0);
    repeat (12) @(posedge bclk); #1;
    chk("R6 ready", 32'(b_ready), 1);
    stby_m = 0; wr(base_word());
    repeat (5) @(posedge bclk); #1;
    chk("R6 drop", 32'(b_ready), 0);

    // R7 status flags
    for (int k = 0; k < 6; k++) begin
      @(negedge bclk); fl_m = 8'($urandom); b_flags = fl_m;
      wait_clk(12);
      chk("R7 flags", rd_data, exp_word());
      r = $urandom & FLM;
      wr(base_word() | r);
      chk("R7 write ignored", rd_data, exp_word());
    end

    // R8 sticky errors
    @(negedge bclk); b_tx_underrun = 1; @(negedge bclk); b_tx_underrun = 0;
    wait_clk(12); te_m = 1;
    chk("R8 tx set", rd_data, exp_word());
    wr(base_word());
    chk("R8 zero keeps", rd_data, exp_word());
    @(negedge bclk); b_rx_overrun = 1; @(negedge bclk); b_rx_overrun = 0;
    wait_clk(12); re_m = 1;
    chk("R8 rx set", rd_data, exp_word());
    wr(base_word() | (32'h1 << 15)); te_m = 0;
    chk("R8 tx w1c", rd_data, exp_word());
    r0 = 0;
    wr(base_word() | (32'h1 << 16)); re_m = 0;
    chk("R8 rx w1c", rd_data, exp_word() | 32'(r0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule